// File: doc/BRIEF.md
# Eight-Channel Event Scaler Bank with Windowed Rate Readout

This block counts pulses on eight independent signals, one free-running counter per signal. Each channel has its own enable, and a channel stops moving while its enable is low. Every channel also keeps a sticky flag that records a wrap of its counter past all ones. A single clear command zeroes the whole bank at once.

Software does not read the live counters directly. A transfer strobe copies all eight live totals into shadow registers in the same clock cycle, so a readout is always a consistent snapshot. Alongside the totals, each channel also counts events inside a fixed measurement window, three seconds by default. At every window boundary the window count moves into a per-channel rate register and restarts from zero. A mode input chooses whether the read port returns the snapshot total or the last completed window count for the channel named on the channel-select input.

Count sources are treated as asynchronous. They pass through a two-stage synchroniser, and each low-to-high transition counts exactly once, however long the level stays high.

Top module: `scaler_bank`

## Requirements
- R1: While reset is asserted, and after it is released, all totals, shadows, window counts, rate registers and overflow flags are zero, so the read port returns 0 and `ovf_flag` is all zeros.
- R2: Each low-to-high transition on `cnt_src[i]` adds one to live counter i when `cnt_en[i]` is high. A level held high counts once. The transition is counted at the third rising clock edge after the first edge that samples the source high.
- R3: While `cnt_en[i]` is low, transitions on `cnt_src[i]` are ignored and live counter i keeps its value.
- R4: `ovf_flag[i]` becomes 1 when counter i is incremented from all ones to zero. It then stays 1 until a clear.
- R5: A cycle with `clr_all` high zeroes every live counter, window count, rate register and overflow flag, and restarts the window timer. A count edge in the same cycle is lost. Shadow registers are not changed by the clear.
- R6: A cycle with `xfer` high copies each live counter, as it stood before that cycle's update, into its shadow register. With `rate_mode` = 0 the read port returns the shadow register of the channel whose binary index is on `rd_chan`.
- R7: With `rate_mode` = 1 the read port returns the rate register of channel `rd_chan`. Every `WIN_CYC` clock cycles, each rate register takes that channel's window count, including an edge counted on the boundary cycle, and the window count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_src | input | NUM_CH | Asynchronous count sources, one per channel |
| cnt_en | input | NUM_CH | Per-channel count enable |
| clr_all | input | 1 | Clear command for the whole bank (one cycle per clear) |
| xfer | input | 1 | Transfer strobe: live totals to shadow registers |
| rate_mode | input | 1 | Read selection: 0 = snapshot total, 1 = windowed rate |
| rd_chan | input | $clog2(NUM_CH) | Channel index for the read port |
| rd_data | output | CNT_W | Read data for the selected channel and mode |
| ovf_flag | output | NUM_CH | Sticky overflow flag per channel |

## Verification
Some properties are checked by assertions on every cycle. These are: a synchronised edge produces a single-cycle pulse, a disabled channel's counter stays stable, overflow flags stay set, a clear leaves zeros behind, a transfer captures the previous live value, and the window timer stays in range. Other behaviour needs the bench's scenarios against its behavioural reference model. That covers the exact three-edge latency, a held level counting once, a clear beating a coincident edge, shadows surviving a clear, a counter wrapping past all ones, and the rate value produced by a steady pulse train over several windows.

// File: rtl/scaler_pkg.sv
package scaler_pkg;
  typedef enum logic {
    RD_TOTAL = 1'b0,
    RD_RATE  = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/scl_sync_edge.sv
module scl_sync_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  logic [W-1:0] meta_q, stab_q, prev_q;
  logic [W-1:0] meta_d, stab_d, prev_d;

  always_comb begin
    meta_d = din;
    stab_d = meta_q;
    prev_d = stab_q;
    rise   = stab_q & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
      prev_q <= prev_d;
    end
  end

  // R2: an edge pulse never lasts longer than one cycle
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/scl_window.sv
module scl_window #(
  parameter int WIN_CYC = 300_000_000
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic clr,
  output logic tick
);
  localparam int WW = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
  localparam logic [WW-1:0] LAST = WW'(WIN_CYC - 1);

  logic [WW-1:0] wcnt_q, wcnt_d;

  always_comb begin
    tick = (wcnt_q == LAST);
    if (clr || tick) wcnt_d = '0;
    else             wcnt_d = wcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) wcnt_q <= '0;
    else         wcnt_q <= wcnt_d;
  end

  // R7
  window_range_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    32'(wcnt_q) < WIN_CYC);
endmodule

// File: rtl/scl_chan.sv
module scl_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             pulse,
  input  logic             en,
  input  logic             clr,
  input  logic             xfer,
  input  logic             tick,
  output logic [CNT_W-1:0] shadow_o,
  output logic [CNT_W-1:0] rate_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] live_q, live_d, win_q, win_d, rate_q, rate_d, shad_q, shad_d;
  logic             ovf_q, ovf_d, inc;
  logic             live_ce, win_ce, rate_ce, shad_ce;

  always_comb begin
    inc    = pulse & en;
    live_d = live_q;
    win_d  = win_q;
    rate_d = rate_q;
    shad_d = live_q;
    ovf_d  = ovf_q;
    if (clr) begin
      live_d = '0;
      win_d  = '0;
      rate_d = '0;
      ovf_d  = 1'b0;
    end else begin
      if (inc) begin
        live_d = live_q + 1'b1;
        if (&live_q) ovf_d = 1'b1;
      end
      if (tick) begin
        rate_d = win_q + {{(CNT_W-1){1'b0}}, inc};
        win_d  = '0;
      end else if (inc) begin
        win_d = win_q + 1'b1;
      end
    end
    live_ce = clr | inc;
    win_ce  = clr | tick | inc;
    rate_ce = clr | tick;
    shad_ce = xfer;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      win_q  <= '0;
      rate_q <= '0;
      shad_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (live_ce) live_q <= live_d;
      if (win_ce)  win_q  <= win_d;
      if (rate_ce) rate_q <= rate_d;
      if (shad_ce) shad_q <= shad_d;
      ovf_q <= ovf_d;
    end
  end

  assign shadow_o = shad_q;
  assign rate_o   = rate_q;
  assign ovf_o    = ovf_q;

  // R3
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!en && !clr) |=> $stable(live_q));
  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ovf_q && !clr) |=> ovf_q);
  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    clr |=> (live_q == '0 && !ovf_q && rate_q == '0 && win_q == '0));
  // R6
  xfer_capture_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    xfer |=> (shad_q == $past(live_q)));
endmodule

// File: rtl/scaler_bank.sv
module scaler_bank #(
  parameter int NUM_CH  = 8,
  parameter int CNT_W   = 32,
  parameter int WIN_CYC = 300_000_000,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cnt_src,
  input  logic [NUM_CH-1:0] cnt_en,
  input  logic              clr_all,
  input  logic              xfer,
  input  logic              rate_mode,
  input  logic [CH_W-1:0]   rd_chan,
  output logic [CNT_W-1:0]  rd_data,
  output logic [NUM_CH-1:0] ovf_flag
);
  import scaler_pkg::*;

  logic rst_meta_q, rst_i;
  logic [NUM_CH-1:0] rise;
  logic tick;
  logic [CNT_W-1:0] shad_arr [NUM_CH];
  logic [CNT_W-1:0] rate_arr [NUM_CH];
  rd_mode_e rd_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_i      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_i      <= rst_meta_q;
    end
  end

  scl_sync_edge #(.W(NUM_CH)) i_edge (
    .clk(clk), .rst_ni(rst_i), .din(cnt_src), .rise(rise)
  );

  scl_window #(.WIN_CYC(WIN_CYC)) i_win (
    .clk(clk), .rst_ni(rst_i), .clr(clr_all), .tick(tick)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    scl_chan #(.CNT_W(CNT_W)) i_chan (
      .clk(clk), .rst_ni(rst_i), .pulse(rise[g]), .en(cnt_en[g]),
      .clr(clr_all), .xfer(xfer), .tick(tick),
      .shadow_o(shad_arr[g]), .rate_o(rate_arr[g]), .ovf_o(ovf_flag[g])
    );
  end

  always_comb begin
    rd_mode = rd_mode_e'(rate_mode);
    if (rd_mode == RD_RATE) rd_data = rate_arr[rd_chan];
    else                    rd_data = shad_arr[rd_chan];
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    (!rst_i) |-> (ovf_flag == '0 && rd_data == '0));
endmodule

// File: tb/test_scaler_bank.sv
module test_scaler_bank;
  localparam int NCH = 8;
  localparam int CW  = 8;
  localparam int WIN = 40;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] cnt_src, cnt_en;
  logic clr_all, xfer, rate_mode;
  logic [2:0] rd_chan;
  logic [CW-1:0] rd_data;
  logic [NCH-1:0] ovf_flag;

  int n_chk = 0, n_fail = 0;
  bit rot = 1'b1;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  scaler_bank #(.NUM_CH(NCH), .CNT_W(CW), .WIN_CYC(WIN)) i_scaler_bank (
    .clk(clk), .rst_n(rst_n), .cnt_src(cnt_src), .cnt_en(cnt_en),
    .clr_all(clr_all), .xfer(xfer), .rate_mode(rate_mode),
    .rd_chan(rd_chan), .rd_data(rd_data), .ovf_flag(ovf_flag)
  );

  // behavioural reference model
  int m_s1[NCH], m_s2[NCH], m_s3[NCH];
  int m_cnt[NCH], m_win[NCH], m_rate[NCH], m_sh[NCH];
  bit m_ov[NCH];
  int m_wc;
  bit m_r1, m_r2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0;
        m_cnt[i] = 0; m_win[i] = 0; m_rate[i] = 0; m_sh[i] = 0; m_ov[i] = 0;
      end
      m_wc = 0; m_r1 = 0; m_r2 = 0;
    end else begin
      if (m_r2) begin
        bit tk;
        tk = (m_wc == WIN - 1);
        for (int i = 0; i < NCH; i++) begin
          int inc;
          inc = (m_s2[i] == 1 && m_s3[i] == 0 && cnt_en[i]) ? 1 : 0;
          if (xfer) m_sh[i] = m_cnt[i];
          if (clr_all) begin
            m_cnt[i] = 0; m_win[i] = 0; m_rate[i] = 0; m_ov[i] = 0;
          end else begin
            if (inc == 1 && m_cnt[i] == MAXV) m_ov[i] = 1;
            m_cnt[i] = (m_cnt[i] + inc) & MAXV;
            if (tk) begin
              m_rate[i] = (m_win[i] + inc) & MAXV;
              m_win[i] = 0;
            end else begin
              m_win[i] = (m_win[i] + inc) & MAXV;
            end
          end
          m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = int'(cnt_src[i]);
        end
        if (clr_all) m_wc = 0;
        else m_wc = tk ? 0 : m_wc + 1;
      end
      m_r2 = m_r1; m_r1 = 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_ovvec();
    int v = 0;
    for (int i = 0; i < NCH; i++) if (m_ov[i]) v |= (1 << i);
    return v;
  endfunction

  // one clock: compare against the model 3 ns after the edge, then rotate the read channel
  task automatic cyc();
    @(posedge clk);
    #3;
    if (rst_n) begin
      chk("R4 overflow flags", int'(ovf_flag), m_ovvec());
      if (rate_mode) chk("R7 rate readout", int'(rd_data), m_rate[rd_chan]);
      else           chk("R6 total readout", int'(rd_data), m_sh[rd_chan]);
    end
    if (rot) rd_chan = rd_chan + 3'd1;
  endtask

  task automatic cycn(input int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic peek(input int ch, input bit mode, input int exp, input string tag);
    rd_chan = 3'(ch);
    rate_mode = mode;
    #1;
    chk(tag, int'(rd_data), exp);
  endtask

  task automatic pulse_ch(input int ch, input int hi, input int lo);
    cnt_src[ch] = 1'b1; cycn(hi);
    cnt_src[ch] = 1'b0; cycn(lo);
  endtask

  task automatic do_xfer();
    xfer = 1'b1; cyc(); xfer = 1'b0; cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cnt_src = '0; cnt_en = '1; clr_all = 0; xfer = 0;
    rate_mode = 0; rd_chan = 0;
    cycn(3);
    // R1: reset state
    chk("R1 ovf in reset", int'(ovf_flag), 0);
    peek(0, 0, 0, "R1 total in reset");
    peek(5, 1, 0, "R1 rate in reset");
    @(posedge clk); #3; rst_n = 1'b1;
    cycn(5);
    peek(2, 0, 0, "R1 total after release");

    // R2: edges count once; held level counts once
    for (int k = 0; k < 3; k++) pulse_ch(0, 2, 2);
    cnt_src[3] = 1'b1; cycn(10); cnt_src[3] = 1'b0;
    cycn(4);
    do_xfer();
    rot = 0;
    peek(0, 0, 3, "R2 three edges on channel 0");
    peek(3, 0, 1, "R2 held level on channel 3");
    rot = 1;

    // R2: latency of exactly three edges
    rot = 0; rd_chan = 6; rate_mode = 0;
    cnt_src[6] = 1'b1; cyc(); cyc();
    xfer = 1'b1; cyc(); xfer = 1'b0;
    peek(6, 0, 0, "R2 not counted before third edge");
    xfer = 1'b1; cyc(); xfer = 1'b0;
    peek(6, 0, 1, "R2 counted at third edge");
    cnt_src[6] = 1'b0; cycn(3);
    rot = 1;

    // R3: disabled channel ignores edges
    cnt_en[1] = 1'b0;
    pulse_ch(1, 2, 3); pulse_ch(1, 2, 3);
    cycn(3);
    cnt_en[1] = 1'b1;
    pulse_ch(1, 2, 5);
    do_xfer();
    rot = 0; peek(1, 0, 1, "R3 disabled edges ignored"); rot = 1;

    // R4: wrap past all ones sets sticky flag
    for (int k = 0; k < MAXV + 1; k++) pulse_ch(2, 1, 1);
    cycn(4);
    chk("R4 flag set after wrap", int'(ovf_flag[2]), 1);
    do_xfer();
    rot = 0; peek(2, 0, 0, "R4 counter wrapped to zero"); rot = 1;
    pulse_ch(2, 1, 5);
    chk("R4 flag stays set", int'(ovf_flag[2]), 1);

    // R7: steady train, period 4 divides the window
    rate_mode = 1;
    for (int k = 0; k < (3 * WIN) / 4; k++) pulse_ch(4, 2, 2);
    rot = 0; peek(4, 1, WIN / 4, "R7 rate of steady train"); rot = 1;
    cycn(2 * WIN);
    rot = 0; peek(4, 1, 0, "R7 idle window gives zero"); rot = 1;

    // R5: clear beats a coincident edge, shadows survive
    rate_mode = 0;
    pulse_ch(5, 2, 2); pulse_ch(5, 2, 4);
    do_xfer();
    cnt_src[0] = 1'b1; cyc(); cyc();
    clr_all = 1'b1; cyc(); clr_all = 1'b0;
    cnt_src[0] = 1'b0;
    chk("R5 flags cleared", int'(ovf_flag), 0);
    rot = 0; peek(5, 0, 2, "R5 shadow kept over clear"); rot = 1;
    cycn(4);
    do_xfer();
    rot = 0;
    peek(0, 0, 0, "R5 coincident edge lost");
    peek(5, 0, 0, "R5 channel 5 cleared");
    peek(4, 1, 0, "R5 rate cleared");
    rot = 1;

    // mixed activity, model compare every cycle in both modes
    for (int k = 0; k < 300; k++) begin
      cnt_src = 8'(k * 37 + (k >> 2));
      cnt_en = 8'(~(k >> 3));
      xfer = (k % 7 == 0);
      rate_mode = ((k / 50) % 2) == 1;
      clr_all = (k == 211);
      cyc();
    end
    cnt_src = '0; xfer = 0; clr_all = 0;
    cycn(10);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule